// File: doc/BRIEF.md
# Configurable Compute Accelerator Array

This block is a small grid of integer function units that evaluates a whole dataflow subgraph in one invocation. Four 32-bit operands and a 132-bit configuration word are presented together with a start pulse. One clock edge later the two selected results appear on registered outputs with a valid flag. The configuration word is produced per invocation by the surrounding control logic. It sets what every unit computes, where each unit takes its two operands from, and which unit outputs reach the two results.

The grid has four rows. Rows 0 and 2 hold four arithmetic/logic units each. Rows 1 and 3 hold two logic-only units each. A unit can read any of the four array operands, the first three outputs of the row directly above it, or a shared 16-bit sign-extended constant. This allows chains such as masking a value with a constant, sign-extending another and merging the two to finish in a single pass.

Top module: `cca_array`

## Requirements
- R1: While rst_ni is low, valid_o, res0_o and res1_o are all zero.
- R2: valid_o is high in exactly the cycle after a cycle with start_i high, and low otherwise.
- R3: res0_o and res1_o only change on a clock edge where start_i is high. Other edges leave them unchanged, whatever cfg_i and opnd_i do.
- R4: Arithmetic-row units (rows 0 and 2) decode their 3-bit op as follows: 0 passes operand A, 1 gives A+B, 2 gives A-B, 3 gives A&B, 4 gives A|B, 5 gives A^B, and 6 and 7 give zero. Sums and differences wrap modulo 2^32.
- R5: Logic-row units (rows 1 and 3) decode their 3-bit op as follows: 0 gives A&B, 1 gives A|B, 2 gives A^B, 3 gives A shifted left by B[4:0], 4 gives a logical right shift by B[4:0], 5 gives an arithmetic right shift by B[4:0], 6 sign-extends A[7:0] and 7 sign-extends A[15:0].
- R6: Each 3-bit operand select works as follows. Codes 0 to 3 pick array operand 0 to 3 (opnd_i[32k+31:32k]). Codes 4 to 6 pick unit 0 to 2 of the row directly above. Code 7 picks the sign-extended immediate. Codes 4 to 6 give zero in row 0, and also when the row above has no such unit.
- R7: Units are numbered 0 to 11 row by row: row 0 is 0-3, row 1 is 4-5, row 2 is 6-9 and row 3 is 10-11. A 4-bit output select of 0 to 11 delivers that unit's value. Selects 12 to 15 deliver zero.
- R8: cfg_i layout. Bits [15:0] hold the immediate. Bits [19:16] are the res0_o select and bits [23:20] the res1_o select. Unit n uses bits starting at 24+9n: op in [2:0], operand A select in [5:3] and operand B select in [8:6], relative to that start.
- R9: Any configuration of all rows, chains four rows deep included, yields results equal to evaluating the subgraph row by row from the values captured at the start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Invocation pulse; captures a result at the next edge |
| cfg_i | input | 132 | Per-invocation configuration word |
| opnd_i | input | 128 | Four 32-bit array operands, operand k at bits 32k+31:32k |
| res0_o | output | 32 | First registered result |
| res1_o | output | 32 | Second registered result |
| valid_o | output | 1 | Result valid, one cycle after start_i |

## Verification
The hardest situation to reach from the ports is a deep chain in which a value passes through all four rows and meets the row-above taps and the immediate along the way. Only the outputs chosen by the two selects are visible, so an error in the middle of a chain stays hidden unless the selects point at the affected node. The stimulus therefore drives hundreds of fully random configuration words, which spread the selects over every node and every operand code, and it adds directed sweeps. These sweeps chain one unit through each op, operand code and output select, and place boundary operands such as overflow values and shift amounts of 0, 31 and above 31.

// File: rtl/cca_pkg.sv
package cca_pkg;
  localparam int OP_W       = 3;
  localparam int SEL_W      = 3;
  localparam int UNIT_CFG_W = OP_W + 2 * SEL_W;

  typedef enum logic [OP_W-1:0] {
    AOP_PASS = 3'd0,
    AOP_ADD  = 3'd1,
    AOP_SUB  = 3'd2,
    AOP_AND  = 3'd3,
    AOP_OR   = 3'd4,
    AOP_XOR  = 3'd5
  } arith_op_e;

  typedef enum logic [OP_W-1:0] {
    LOP_AND  = 3'd0,
    LOP_OR   = 3'd1,
    LOP_XOR  = 3'd2,
    LOP_SHL  = 3'd3,
    LOP_SHR  = 3'd4,
    LOP_SRA  = 3'd5,
    LOP_SXB  = 3'd6,
    LOP_SXH  = 3'd7
  } logic_op_e;
endpackage

// File: rtl/cca_opnd_mux.sv
module cca_opnd_mux
  import cca_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_IN   = 4,
  parameter int N_TAP  = 3
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] arr_i [N_IN],
  input  logic [DATA_W-1:0] tap_i [N_TAP],
  input  logic [DATA_W-1:0] imm_i,
  output logic [DATA_W-1:0] val_o
);
  always_comb begin
    val_o = imm_i;
    for (int k = 0; k < N_IN; k++)
      if (sel_i == SEL_W'(k)) val_o = arr_i[k];
    for (int k = 0; k < N_TAP; k++)
      if (sel_i == SEL_W'(N_IN + k)) val_o = tap_i[k];
  end
endmodule

// File: rtl/cca_fu.sv
module cca_fu
  import cca_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit IS_ARITH = 1'b1
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int SH_W = $clog2(DATA_W);

  generate
    if (IS_ARITH) begin : g_arith
      always_comb begin
        case (arith_op_e'(op_i))
          AOP_PASS: y_o = a_i;
          AOP_ADD:  y_o = a_i + b_i;
          AOP_SUB:  y_o = a_i - b_i;
          AOP_AND:  y_o = a_i & b_i;
          AOP_OR:   y_o = a_i | b_i;
          AOP_XOR:  y_o = a_i ^ b_i;
          default:  y_o = '0;
        endcase
      end
    end else begin : g_logic
      logic [SH_W-1:0] sh;
      assign sh = b_i[SH_W-1:0];
      always_comb begin
        case (logic_op_e'(op_i))
          LOP_AND: y_o = a_i & b_i;
          LOP_OR:  y_o = a_i | b_i;
          LOP_XOR: y_o = a_i ^ b_i;
          LOP_SHL: y_o = a_i << sh;
          LOP_SHR: y_o = a_i >> sh;
          LOP_SRA: y_o = DATA_W'($signed(a_i) >>> sh);
          LOP_SXB: y_o = {{(DATA_W-8){a_i[7]}}, a_i[7:0]};
          default: y_o = {{(DATA_W-16){a_i[15]}}, a_i[15:0]};
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/cca_out_mux.sv
module cca_out_mux #(
  parameter int DATA_W  = 32,
  parameter int N_NODES = 12,
  parameter int SEL_W   = 4
) (
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [DATA_W-1:0] node_i [N_NODES],
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    y_o = '0;
    for (int i = 0; i < N_NODES; i++)
      if (sel_i == SEL_W'(i)) y_o = node_i[i];
  end
endmodule

// File: rtl/cca_array.sv
module cca_array
  import cca_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int N_IN    = 4,
  parameter int ARITH_W = 4,
  parameter int LOGIC_W = 2,
  parameter int N_ROWS  = 4,
  parameter int IMM_W   = 16,
  localparam int N_TAP    = (1 << SEL_W) - N_IN - 1,
  localparam int MAX_W    = (ARITH_W > LOGIC_W) ? ARITH_W : LOGIC_W,
  localparam int N_UNITS  = (N_ROWS / 2) * (ARITH_W + LOGIC_W) + (N_ROWS % 2) * ARITH_W,
  localparam int OSEL_W   = $clog2(N_UNITS + 1),
  localparam int OSEL0_LO = IMM_W,
  localparam int OSEL1_LO = IMM_W + OSEL_W,
  localparam int UNIT_LO  = IMM_W + 2 * OSEL_W,
  localparam int CFG_W    = UNIT_LO + N_UNITS * UNIT_CFG_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [CFG_W-1:0]       cfg_i,
  input  logic [N_IN*DATA_W-1:0] opnd_i,
  output logic [DATA_W-1:0]      res0_o,
  output logic [DATA_W-1:0]      res1_o,
  output logic                   valid_o
);
  function automatic int row_width(int r);
    return (r % 2 == 0) ? ARITH_W : LOGIC_W;
  endfunction

  function automatic int row_base(int r);
    return (r / 2) * (ARITH_W + LOGIC_W) + ((r % 2 != 0) ? ARITH_W : 0);
  endfunction

  logic [DATA_W-1:0] opnd    [N_IN];
  logic [DATA_W-1:0] imm_ext;
  logic [DATA_W-1:0] row_val [N_ROWS][MAX_W];
  logic [DATA_W-1:0] nodes   [N_UNITS];
  logic [DATA_W-1:0] out0, out1;
  logic [DATA_W-1:0] res0_q, res1_q;
  logic              valid_q;

  assign imm_ext = {{(DATA_W-IMM_W){cfg_i[IMM_W-1]}}, cfg_i[IMM_W-1:0]};

  generate
    for (genvar k = 0; k < N_IN; k++) begin : g_opnd
      assign opnd[k] = opnd_i[k*DATA_W +: DATA_W];
    end

    for (genvar r = 0; r < N_ROWS; r++) begin : g_row
      localparam int W = row_width(r);
      localparam int B = row_base(r);
      logic [DATA_W-1:0] tap [N_TAP];

      for (genvar k = 0; k < N_TAP; k++) begin : g_tap
        if (r > 0 && k < row_width(r - 1)) begin : g_live
          assign tap[k] = row_val[r-1][k];
        end else begin : g_dead
          assign tap[k] = '0;
        end
      end

      for (genvar u = 0; u < MAX_W; u++) begin : g_unit
        if (u < W) begin : g_fu
          localparam int LO = UNIT_LO + (B + u) * UNIT_CFG_W;
          logic [DATA_W-1:0] a, b;

          cca_opnd_mux #(.DATA_W(DATA_W), .N_IN(N_IN), .N_TAP(N_TAP)) u_mux_a (
            .sel_i (cfg_i[LO+OP_W +: SEL_W]),
            .arr_i (opnd),
            .tap_i (tap),
            .imm_i (imm_ext),
            .val_o (a)
          );
          cca_opnd_mux #(.DATA_W(DATA_W), .N_IN(N_IN), .N_TAP(N_TAP)) u_mux_b (
            .sel_i (cfg_i[LO+OP_W+SEL_W +: SEL_W]),
            .arr_i (opnd),
            .tap_i (tap),
            .imm_i (imm_ext),
            .val_o (b)
          );
          cca_fu #(.DATA_W(DATA_W), .IS_ARITH(r % 2 == 0)) u_fu (
            .op_i (cfg_i[LO +: OP_W]),
            .a_i  (a),
            .b_i  (b),
            .y_o  (row_val[r][u])
          );
          assign nodes[B+u] = row_val[r][u];
        end else begin : g_pad
          assign row_val[r][u] = '0;
        end
      end
    end
  endgenerate

  cca_out_mux #(.DATA_W(DATA_W), .N_NODES(N_UNITS), .SEL_W(OSEL_W)) u_out0 (
    .sel_i  (cfg_i[OSEL0_LO +: OSEL_W]),
    .node_i (nodes),
    .y_o    (out0)
  );
  cca_out_mux #(.DATA_W(DATA_W), .N_NODES(N_UNITS), .SEL_W(OSEL_W)) u_out1 (
    .sel_i  (cfg_i[OSEL1_LO +: OSEL_W]),
    .node_i (nodes),
    .y_o    (out1)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      res0_q  <= '0;
      res1_q  <= '0;
    end else begin
      valid_q <= start_i;
      if (start_i) begin
        res0_q <= out0;
        res1_q <= out1;
      end
    end
  end

  assign res0_o  = res0_q;
  assign res1_o  = res1_q;
  assign valid_o = valid_q;

  AST_VALID_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o); // R2
  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o); // R2
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> ($stable(res0_o) && $stable(res1_o))); // R3
  AST_OSEL0_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cfg_i[OSEL0_LO +: OSEL_W] >= OSEL_W'(N_UNITS)) |=> res0_o == '0); // R7
  AST_OSEL1_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && cfg_i[OSEL1_LO +: OSEL_W] >= OSEL_W'(N_UNITS)) |=> res1_o == '0); // R7
endmodule

// File: tb/cca_array_test.sv
module cca_array_test;
  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [131:0]  cfg = '0;
  logic [127:0]  opnd = '0;
  logic [31:0]   r0, r1;
  logic          vld;

  int            checks = 0;
  int            fails = 0;
  string         cur_req = "R1";
  logic [31:0]   e0 = '0, e1 = '0, t0, t1;
  logic          ev = 1'b0;

  always #5 clk = ~clk;

  cca_array uut (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .cfg_i (cfg),
    .opnd_i (opnd), .res0_o (r0), .res1_o (r1), .valid_o (vld)
  );

  // Behavioural evaluation of a configuration, node by node
  function automatic void model(input logic [131:0] c, input logic [127:0] x,
                                output logic [31:0] o0, output logic [31:0] o1);
    logic [31:0] nv [12];
    int start_of [4] = '{0, 4, 6, 10};
    int width_of [4] = '{4, 2, 4, 2};
    for (int r = 0; r < 4; r++) begin
      for (int u = 0; u < width_of[r]; u++) begin
        int n = start_of[r] + u;
        int lo = 24 + 9 * n;
        logic [2:0] op = c[lo +: 3];
        logic [31:0] v [2];
        logic [31:0] a, b;
        for (int s = 0; s < 2; s++) begin
          int code = int'(c[lo + 3 + 3 * s +: 3]);
          if (code < 4) v[s] = x[32 * code +: 32];
          else if (code == 7) v[s] = {{16{c[15]}}, c[15:0]};
          else if (r == 0 || (code - 4) >= width_of[r-1]) v[s] = 32'd0;
          else v[s] = nv[start_of[r-1] + code - 4];
        end
        a = v[0];
        b = v[1];
        if (r % 2 == 0) begin
          case (op)
            3'd0: nv[n] = a;
            3'd1: nv[n] = a + b;
            3'd2: nv[n] = a - b;
            3'd3: nv[n] = a & b;
            3'd4: nv[n] = a | b;
            3'd5: nv[n] = a ^ b;
            default: nv[n] = 32'd0;
          endcase
        end else begin
          case (op)
            3'd0: nv[n] = a & b;
            3'd1: nv[n] = a | b;
            3'd2: nv[n] = a ^ b;
            3'd3: nv[n] = a << b[4:0];
            3'd4: nv[n] = a >> b[4:0];
            3'd5: nv[n] = $signed(a) >>> b[4:0];
            3'd6: nv[n] = {{24{a[7]}}, a[7:0]};
            default: nv[n] = {{16{a[15]}}, a[15:0]};
          endcase
        end
      end
    end
    o0 = (c[19:16] < 4'd12) ? nv[c[19:16]] : 32'd0;
    o1 = (c[23:20] < 4'd12) ? nv[c[23:20]] : 32'd0;
  endfunction

  function automatic logic [131:0] set_unit(logic [131:0] c, int n, int op, int sa, int sb);
    logic [131:0] r = c;
    r[24 + 9 * n +: 9] = {3'(sb), 3'(sa), 3'(op)};
    return r;
  endfunction

  function automatic logic [131:0] rand_cfg();
    return {$urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] rand_opnd();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  // reference register stage
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev <= 1'b0; e0 <= '0; e1 <= '0;
    end else begin
      ev <= start;
      if (start) begin
        model(cfg, opnd, t0, t1);
        e0 <= t0;
        e1 <= t1;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (vld !== ev || r0 !== e0 || r1 !== e1) begin
        fails++;
        $display("FAIL %s (R2/R3 timing): got v=%0b r0=%h r1=%h exp v=%0b r0=%h r1=%h",
                 cur_req, vld, r0, r1, ev, e0, e1);
      end
    end
  end

  task automatic fire(logic [131:0] c, logic [127:0] x, string req);
    @(negedge clk);
    cur_req = req;
    cfg = c; opnd = x; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin : watchdog
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : stim
    logic [131:0] c;
    #12;
    checks++;
    if (vld !== 1'b0 || r0 !== 32'd0 || r1 !== 32'd0) begin
      fails++;
      $display("FAIL R1: got v=%0b r0=%h r1=%h exp 0 0 0", vld, r0, r1);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R4: every arithmetic op on unit 0 (row 0), boundary operands
    for (int op = 0; op < 8; op++) begin
      c = set_unit('0, 0, op, 0, 1);
      c[19:16] = 4'd0; c[23:20] = 4'd1;
      fire(c, {32'd9, 32'd3, 32'h0000_0001, 32'h7FFF_FFFF}, "R4");
      fire(c, {32'd0, 32'd0, 32'hFFFF_FFFF, 32'h0000_0000}, "R4");
      fire(c, rand_opnd(), "R4");
    end

    // R5: every logic op on unit 4 (row 1), shift amounts 0, 31, 36, 8
    for (int op = 0; op < 8; op++) begin
      c = set_unit('0, 4, op, 0, 1);
      c[19:16] = 4'd4; c[23:20] = 4'd5;
      fire(c, {64'd0, 32'd0, 32'h8000_80F1}, "R5");
      fire(c, {64'd0, 32'd31, 32'h8765_4321}, "R5");
      fire(c, {64'd0, 32'd36, 32'hF000_7F80}, "R5");
      fire(c, {64'd0, 32'd8, $urandom}, "R5");
    end

    // R6: every operand code on row 0, row 1 and row 2 units, negative immediate
    for (int s = 0; s < 8; s++) begin
      c = '0;
      for (int n = 1; n < 4; n++) c = set_unit(c, n, 0, n, 0);
      c = set_unit(c, 0, 0, s, 0);
      c = set_unit(c, 4, 1, s, s);
      c = set_unit(c, 5, 2, 0, 1);
      c = set_unit(c, 6, 0, s, 0);
      c[15:0] = 16'h8001;
      c[19:16] = 4'd0; c[23:20] = 4'd4;
      fire(c, rand_opnd(), "R6");
      c[19:16] = 4'd6; c[23:20] = 4'd0;
      fire(c, rand_opnd(), "R6");
    end

    // R7: every output select value over random configurations
    for (int s = 0; s < 16; s++) begin
      c = rand_cfg();
      c[19:16] = 4'(s); c[23:20] = 4'(15 - s);
      fire(c, rand_opnd(), "R7");
    end

    // R8/R9: mask with constant, sign-extend, merge through all rows
    c = '0;
    c[15:0] = 16'hFFFC;
    c = set_unit(c, 0, 3, 1, 7);
    c = set_unit(c, 1, 0, 2, 0);
    c = set_unit(c, 4, 6, 5, 5);
    c = set_unit(c, 5, 0, 4, 7);
    c = set_unit(c, 6, 4, 5, 4);
    c = set_unit(c, 7, 1, 4, 5);
    c = set_unit(c, 10, 4, 4, 3);
    c = set_unit(c, 11, 2, 5, 6);
    for (int k = 0; k < 4; k++) begin
      c[19:16] = 4'(10 + (k % 2)); c[23:20] = 4'(6 + k);
      fire(c, rand_opnd(), "R9");
    end

    // R3: no start while inputs change, results must hold
    fire(rand_cfg(), rand_opnd(), "R3");
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cur_req = "R3";
      cfg = rand_cfg(); opnd = rand_opnd();
    end

    // R2: back-to-back starts, then gaps
    @(negedge clk);
    cur_req = "R2";
    start = 1'b1;
    for (int k = 0; k < 3; k++) begin
      cfg = rand_cfg(); opnd = rand_opnd();
      @(negedge clk);
    end
    start = 1'b0;

    // R9: random configurations
    for (int k = 0; k < 300; k++) fire(rand_cfg(), rand_opnd(), "R9");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule